// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block decodes and carries out the commands that a hot-plug controller receives on its command byte. It has a narrow write bus with three addresses: a command code byte, a five-bit target byte and an acknowledge location. It keeps, for each of a parameterised number of slots (one to thirty-one), a slot state, a power indicator, an attention indicator, an MRL-open flag, a two-bit presence code and two latched events. It also keeps the command status bits and a sticky command-detected flag.

A write to either the code byte or the target byte starts one command, and the command uses the current values of both. One code range packs a requested state and two indicator settings into a single byte, where a zero field keeps the present value. A second range selects the secondary bus speed. Two codes act on every slot, and these run one slot per clock cycle. When a slot passes from "not off" to "off" (disabled with its power indicator off), it is treated as ejected. Its MRL reads open, its presence reads empty and both of its events latch. A read port selects one slot and shows its fields without any delay.

Top module: `hpcmd_top`

## Requirements
- R1: While `rstN` is low, each slot whose `occupiedAtReset` bit is 1 loads state 2 (enabled), power indicator 1 (on), attention 3 (off), MRL closed, presence 0 and no events. Each other slot loads state 3 (disabled), power 3, attention 3, MRL open, presence 3 and no events. The command status, the detected flag, the code byte and the target byte all reset to 0.
- R2: Codes 0x00 to 0x3F are slot commands. Bits [1:0] request a state (1 power-only, 2 enabled, 3 disabled). Bits [3:2] request a power indicator setting and bits [5:4] an attention setting (1 on, 2 blink, 3 off). A field of 0 leaves that item as it is. The target register holds `wrData[4:0]`, and target t addresses slot index t-1.
- R3: A slot command whose target is 0, or whose index t-1 is not below NSLOTS, sets the invalid-command bit (`cmdStatus[2]`) and leaves every slot unchanged.
- R4: A slot command that requests power-only (state 1) for a slot that is enabled sets the invalid-command bit and changes nothing.
- R5: Codes 0x40 to 0x47 select a bus speed from bits [2:0]. Only speed 0 is accepted. Any other value sets the invalid-mode bit (`cmdStatus[3]`). A single command never sets both error bits.
- R6: Code 0x48 (power-only all) and code 0x49 (enable all) fail with the invalid-command bit, and leave every slot unchanged, if any slot is enabled.
- R7: When accepted, 0x48 and 0x49 update every slot. A slot with its MRL closed gets state 1 (for 0x48) or 2 (for 0x49) and power indicator on. A slot with its MRL open keeps its state and gets power indicator off. The attention indicator is kept in both cases.
- R8: Every code from 0x4A to 0xFF sets the invalid-command bit and changes no slot.
- R9: Each command first clears `cmdStatus[3:1]`. When it completes, it sets `cmdDetected`. Writing 1 to bit 0 at address 2 clears `cmdDetected`. Writing 0 there leaves it set.
- R10: An accepted write to address 0 (code) or address 1 (target) updates that byte and starts a command that uses both current bytes.
- R11: A slot update that takes a slot from not-off to off sets its MRL-open flag and presence code 3, and latches both events (`rdEvents` bit 1 MRL, bit 0 presence). No command ever clears an MRL-open flag.
- R12: `busy` (also `cmdStatus[0]`) is high for 1 cycle after a single command and for NSLOTS+1 cycles after an accepted all-slot command. Every write that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| occupiedAtReset | input | NSLOTS | Per-slot occupancy, sampled while reset is low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | 0 code byte, 1 target byte, 2 acknowledge |
| wrData | input | 8 | Write data |
| rdSlot | input | 5 | Slot index shown on the read port |
| busy | output | 1 | Command in progress |
| cmdStatus | output | 4 | {invalid mode, invalid command, MRL open (always 0), busy} |
| cmdDetected | output | 1 | Sticky command-completed flag |
| rdState | output | 2 | State of the selected slot |
| rdPwrLed | output | 2 | Power indicator of the selected slot |
| rdAttnLed | output | 2 | Attention indicator of the selected slot |
| rdMrlOpen | output | 1 | MRL-open flag of the selected slot |
| rdPresence | output | 2 | Presence code of the selected slot |
| rdEvents | output | 2 | Latched events {MRL, presence} of the selected slot |

## Verification
Slot commands are swept over all 64 codes for each target from 0 to 7 and for target 31, starting from a mix of occupied and empty slots. This separates the kept fields from the written ones, the valid targets from the out-of-range ones, and the rejected enabled-to-power-only requests from accepted ones. As a side effect, ejects are triggered from many different prior states. The speed and undefined code ranges are swept to tell invalid-mode apart from invalid-command. The all-slot codes are tried with an enabled slot present, with a mix of open and closed MRLs, and with an open-MRL slot that is disabled but still lit, which shows that ejection also happens inside an all-slot pass. The busy length, and writes issued during a long command, show the stepping timing and the dropped writes.

// File: rtl/hpcmd_pkg.sv
package hpcmd_pkg;
  localparam int TGT_W = 5;

  localparam logic [1:0] ST_KEEP     = 2'd0;
  localparam logic [1:0] ST_PWRONLY  = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;

  localparam logic [1:0] LED_KEEP = 2'd0;
  localparam logic [1:0] LED_ON   = 2'd1;
  localparam logic [1:0] LED_OFF  = 2'd3;

  localparam logic [1:0] PRES_LOW   = 2'd0;
  localparam logic [1:0] PRES_EMPTY = 2'd3;

  localparam logic [7:0] OP_ALL_PWRONLY = 8'h48;
  localparam logic [7:0] OP_ALL_ENABLE  = 8'h49;

  localparam logic [1:0] ADDR_CODE   = 2'd0;
  localparam logic [1:0] ADDR_TARGET = 2'd1;
  localparam logic [1:0] ADDR_ACK    = 2'd2;

  typedef struct packed {
    logic             clrStatus;
    logic             setInvCmd;
    logic             setInvMode;
    logic             setDetected;
    logic             clrDetected;
    logic             applySlot;
    logic [TGT_W-1:0] slotIdx;
    logic [1:0]       reqState;
    logic [1:0]       reqPower;
    logic [1:0]       reqAttn;
  } ctlStrobe_t;
endpackage

// File: rtl/hpcmd_ctrl.sv
module hpcmd_ctrl
  import hpcmd_pkg::*;
#(
  parameter int NSLOTS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [7:0]             wrData,
  input  logic [NSLOTS-1:0][1:0] stateVec,
  input  logic [NSLOTS-1:0]      mrlVec,
  output logic                   busy,
  output ctlStrobe_t             stb
);
  localparam logic [TGT_W-1:0] LAST_IDX = TGT_W'(NSLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_APPLY} phase_e;

  phase_e           phase;
  logic [7:0]       codeReg;
  logic [TGT_W-1:0] tgtReg;
  logic [TGT_W-1:0] stepIdx;

  logic             acceptWr, startCmd;
  logic             isSlotCmd, isSpeed, isAll, anyEnabled, tgtOk, stepMrl;
  logic [TGT_W-1:0] tgtIdx;
  logic [1:0]       tgtState;

  assign acceptWr  = wrEn && (phase == S_IDLE);
  assign startCmd  = acceptWr && ((wrAddr == ADDR_CODE) || (wrAddr == ADDR_TARGET));
  assign isSlotCmd = (codeReg[7:6] == 2'b00);
  assign isSpeed   = (codeReg[7:3] == 5'b01000);
  assign isAll     = (codeReg == OP_ALL_PWRONLY) || (codeReg == OP_ALL_ENABLE);
  assign tgtIdx    = tgtReg - TGT_W'(1);
  assign tgtOk     = (tgtReg != '0) && (int'(tgtIdx) < NSLOTS);
  assign busy      = (phase != S_IDLE);

  always_comb begin
    anyEnabled = 1'b0;
    tgtState   = ST_KEEP;
    stepMrl    = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (stateVec[i] == ST_ENABLED) anyEnabled = 1'b1;
      if (tgtIdx == TGT_W'(i)) tgtState = stateVec[i];
      if (stepIdx == TGT_W'(i)) stepMrl = mrlVec[i];
    end
  end

  always_comb begin
    stb = '0;
    unique case (phase)
      S_IDLE: begin
        stb.clrDetected = acceptWr && (wrAddr == ADDR_ACK) && wrData[0];
      end
      S_EXEC: begin
        stb.clrStatus = 1'b1;
        if (isSlotCmd) begin
          stb.setDetected = 1'b1;
          if (!tgtOk) begin
            stb.setInvCmd = 1'b1;
          end else if ((tgtState == ST_ENABLED) && (codeReg[1:0] == ST_PWRONLY)) begin
            stb.setInvCmd = 1'b1;
          end else begin
            stb.applySlot = 1'b1;
            stb.slotIdx   = tgtIdx;
            stb.reqState  = codeReg[1:0];
            stb.reqPower  = codeReg[3:2];
            stb.reqAttn   = codeReg[5:4];
          end
        end else if (isSpeed) begin
          stb.setDetected = 1'b1;
          stb.setInvMode  = (codeReg[2:0] != 3'd0);
        end else if (isAll) begin
          stb.setInvCmd   = anyEnabled;
          stb.setDetected = anyEnabled;
        end else begin
          stb.setInvCmd   = 1'b1;
          stb.setDetected = 1'b1;
        end
      end
      S_APPLY: begin
        stb.applySlot   = 1'b1;
        stb.slotIdx     = stepIdx;
        stb.reqAttn     = LED_KEEP;
        stb.setDetected = (stepIdx == LAST_IDX);
        if (stepMrl) begin
          stb.reqState = ST_KEEP;
          stb.reqPower = LED_OFF;
        end else begin
          stb.reqState = codeReg[0] ? ST_ENABLED : ST_PWRONLY;
          stb.reqPower = LED_ON;
        end
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= S_IDLE;
      codeReg <= '0;
      tgtReg  <= '0;
      stepIdx <= '0;
    end else begin
      unique case (phase)
        S_IDLE: begin
          if (startCmd) begin
            phase <= S_EXEC;
            if (wrAddr == ADDR_CODE) codeReg <= wrData;
            else                     tgtReg  <= wrData[TGT_W-1:0];
          end
        end
        S_EXEC: begin
          stepIdx <= '0;
          phase   <= (isAll && !anyEnabled) ? S_APPLY : S_IDLE;
        end
        S_APPLY: begin
          if (stepIdx == LAST_IDX) phase <= S_IDLE;
          else                     stepIdx <= stepIdx + TGT_W'(1);
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpcmd_dp.sv
module hpcmd_dp
  import hpcmd_pkg::*;
#(
  parameter int NSLOTS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSLOTS-1:0]      occupiedAtReset,
  input  ctlStrobe_t             stb,
  input  logic                   busy,
  input  logic [TGT_W-1:0]       rdSlot,
  output logic [3:0]             cmdStatus,
  output logic                   cmdDetected,
  output logic [NSLOTS-1:0][1:0] stateVec,
  output logic [NSLOTS-1:0][1:0] pwrVec,
  output logic [NSLOTS-1:0]      mrlVec,
  output logic [1:0]             rdState,
  output logic [1:0]             rdPwrLed,
  output logic [1:0]             rdAttnLed,
  output logic                   rdMrlOpen,
  output logic [1:0]             rdPresence,
  output logic [1:0]             rdEvents
);
  logic [NSLOTS-1:0][1:0] attnVec, presVec, evtVec;
  logic                   invCmdQ, invModeQ, detQ;

  for (genvar g = 0; g < NSLOTS; g++) begin : gSlot
    logic [1:0] stQ, pwQ, atQ, prQ, evQ;
    logic       mrQ, hit, wasOff, nowOff;
    logic [1:0] stN, pwN, atN;

    assign hit    = stb.applySlot && (stb.slotIdx == TGT_W'(g));
    assign stN    = (stb.reqState == ST_KEEP)  ? stQ : stb.reqState;
    assign pwN    = (stb.reqPower == LED_KEEP) ? pwQ : stb.reqPower;
    assign atN    = (stb.reqAttn  == LED_KEEP) ? atQ : stb.reqAttn;
    assign wasOff = (stQ == ST_DISABLED) && (pwQ == LED_OFF);
    assign nowOff = (stN == ST_DISABLED) && (pwN == LED_OFF);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        atQ <= LED_OFF;
        evQ <= 2'b00;
        if (occupiedAtReset[g]) begin
          stQ <= ST_ENABLED;
          pwQ <= LED_ON;
          mrQ <= 1'b0;
          prQ <= PRES_LOW;
        end else begin
          stQ <= ST_DISABLED;
          pwQ <= LED_OFF;
          mrQ <= 1'b1;
          prQ <= PRES_EMPTY;
        end
      end else if (hit) begin
        stQ <= stN;
        pwQ <= pwN;
        atQ <= atN;
        if (!wasOff && nowOff) begin
          mrQ <= 1'b1;
          prQ <= PRES_EMPTY;
          evQ <= 2'b11;
        end
      end
    end

    assign stateVec[g] = stQ;
    assign pwrVec[g]   = pwQ;
    assign attnVec[g]  = atQ;
    assign mrlVec[g]   = mrQ;
    assign presVec[g]  = prQ;
    assign evtVec[g]   = evQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invCmdQ  <= 1'b0;
      invModeQ <= 1'b0;
      detQ     <= 1'b0;
    end else begin
      if (stb.clrStatus) begin
        invCmdQ  <= stb.setInvCmd;
        invModeQ <= stb.setInvMode;
      end
      if (stb.setDetected)      detQ <= 1'b1;
      else if (stb.clrDetected) detQ <= 1'b0;
    end
  end

  assign cmdStatus   = {invModeQ, invCmdQ, 1'b0, busy};
  assign cmdDetected = detQ;

  always_comb begin
    rdState    = '0;
    rdPwrLed   = '0;
    rdAttnLed  = '0;
    rdMrlOpen  = 1'b0;
    rdPresence = '0;
    rdEvents   = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (rdSlot == TGT_W'(i)) begin
        rdState    = stateVec[i];
        rdPwrLed   = pwrVec[i];
        rdAttnLed  = attnVec[i];
        rdMrlOpen  = mrlVec[i];
        rdPresence = presVec[i];
        rdEvents   = evtVec[i];
      end
    end
  end
endmodule

// File: rtl/hpcmd_top.sv
module hpcmd_top
  import hpcmd_pkg::*;
#(
  parameter int NSLOTS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSLOTS-1:0] occupiedAtReset,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [4:0]        rdSlot,
  output logic              busy,
  output logic [3:0]        cmdStatus,
  output logic              cmdDetected,
  output logic [1:0]        rdState,
  output logic [1:0]        rdPwrLed,
  output logic [1:0]        rdAttnLed,
  output logic              rdMrlOpen,
  output logic [1:0]        rdPresence,
  output logic [1:0]        rdEvents
);
  ctlStrobe_t             stb;
  logic [NSLOTS-1:0][1:0] stateVec, pwrVec;
  logic [NSLOTS-1:0]      mrlVec;

  hpcmd_ctrl #(.NSLOTS(NSLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stateVec(stateVec), .mrlVec(mrlVec), .busy(busy), .stb(stb)
  );

  hpcmd_dp #(.NSLOTS(NSLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .occupiedAtReset(occupiedAtReset), .stb(stb),
    .busy(busy), .rdSlot(rdSlot), .cmdStatus(cmdStatus), .cmdDetected(cmdDetected),
    .stateVec(stateVec), .pwrVec(pwrVec), .mrlVec(mrlVec),
    .rdState(rdState), .rdPwrLed(rdPwrLed), .rdAttnLed(rdAttnLed),
    .rdMrlOpen(rdMrlOpen), .rdPresence(rdPresence), .rdEvents(rdEvents)
  );
endmodule

// File: rtl/hpcmd_chk.sv
module hpcmd_chk #(
  parameter int NSLOTS = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic                   busy,
  input logic [1:0]             errBits,
  input logic                   cmdDetected,
  input logic [NSLOTS-1:0][1:0] stateVec,
  input logic [NSLOTS-1:0][1:0] pwrVec,
  input logic [NSLOTS-1:0]      mrlVec
);
  logic pastValid;
  int   busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      busyRun   <= 0;
    end else begin
      pastValid <= 1'b1;
      busyRun   <= busy ? busyRun + 1 : 0;
    end
  end

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    $rose(busy) |-> $past(wrEn));

  // R12
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= NSLOTS + 1);

  // R9
  detected_rise_chk: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    $rose(cmdDetected) |-> $past(busy));

  // R5
  one_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errBits[0] && errBits[1]));

  for (genvar g = 0; g < NSLOTS; g++) begin : gSlotChk
    // R11
    eject_off_chk: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
      $rose(mrlVec[g]) |-> (stateVec[g] == 2'd3) && (pwrVec[g] == 2'd3));

    // R11
    mrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
      !$fell(mrlVec[g]));
  end
endmodule

bind hpcmd_top hpcmd_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .busy(busy), .errBits(cmdStatus[3:2]),
  .cmdDetected(cmdDetected), .stateVec(stateVec), .pwrVec(pwrVec), .mrlVec(mrlVec)
);

// File: tb/sim_hpcmd_top.sv
module sim_hpcmd_top;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] occupiedAtReset = '0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic [4:0]   rdSlot = '0;
  logic         busy, cmdDetected, rdMrlOpen;
  logic [3:0]   cmdStatus;
  logic [1:0]   rdState, rdPwrLed, rdAttnLed, rdPresence, rdEvents;

  always #10 clk = ~clk;

  hpcmd_top #(.NSLOTS(N)) u0 (
    .clk(clk), .rstN(rstN), .occupiedAtReset(occupiedAtReset), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdSlot(rdSlot), .busy(busy),
    .cmdStatus(cmdStatus), .cmdDetected(cmdDetected), .rdState(rdState),
    .rdPwrLed(rdPwrLed), .rdAttnLed(rdAttnLed), .rdMrlOpen(rdMrlOpen),
    .rdPresence(rdPresence), .rdEvents(rdEvents)
  );

  logic [1:0] mState [N];
  logic [1:0] mPwr   [N];
  logic [1:0] mAttn  [N];
  logic [1:0] mPres  [N];
  logic [1:0] mEvt   [N];
  logic       mMrl   [N];
  logic       mInvCmd, mInvMode, mDet;
  logic [7:0] mCode;
  logic [4:0] mTgt;
  int checks = 0, fails = 0, busyCnt = 0;
  bit finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelReset(logic [N-1:0] occ);
    for (int i = 0; i < N; i++) begin
      mAttn[i] = 2'd3; mEvt[i] = 2'd0;
      if (occ[i]) begin mState[i] = 2'd2; mPwr[i] = 2'd1; mMrl[i] = 1'b0; mPres[i] = 2'd0; end
      else        begin mState[i] = 2'd3; mPwr[i] = 2'd3; mMrl[i] = 1'b1; mPres[i] = 2'd3; end
    end
    mInvCmd = 0; mInvMode = 0; mDet = 0; mCode = 0; mTgt = 0;
  endtask

  task automatic mApply(int i, logic [1:0] st, logic [1:0] pw, logic [1:0] at);
    bit wasOff, nowOff;
    wasOff = (mState[i] == 2'd3) && (mPwr[i] == 2'd3);
    if (st != 0) mState[i] = st;
    if (pw != 0) mPwr[i] = pw;
    if (at != 0) mAttn[i] = at;
    nowOff = (mState[i] == 2'd3) && (mPwr[i] == 2'd3);
    if (!wasOff && nowOff) begin mMrl[i] = 1'b1; mPres[i] = 2'd3; mEvt[i] = 2'b11; end
  endtask

  task automatic mExec();
    bit anyEn;
    int idx;
    mInvCmd = 0; mInvMode = 0;
    if (mCode <= 8'h3F) begin
      idx = int'(mTgt) - 1;
      if (mTgt == 0 || idx >= N) mInvCmd = 1;
      else if (mState[idx] == 2'd2 && mCode[1:0] == 2'd1) mInvCmd = 1;
      else mApply(idx, mCode[1:0], mCode[3:2], mCode[5:4]);
    end else if (mCode <= 8'h47) begin
      if (mCode[2:0] != 0) mInvMode = 1;
    end else if (mCode == 8'h48 || mCode == 8'h49) begin
      anyEn = 0;
      for (int i = 0; i < N; i++) if (mState[i] == 2'd2) anyEn = 1;
      if (anyEn) mInvCmd = 1;
      else
        for (int i = 0; i < N; i++)
          if (!mMrl[i]) mApply(i, (mCode == 8'h49) ? 2'd2 : 2'd1, 2'd1, 2'd0);
          else          mApply(i, 2'd0, 2'd3, 2'd0);
    end else mInvCmd = 1;
    mDet = 1;
  endtask

  task automatic compareAll(string req);
    for (int i = 0; i < N; i++) begin
      rdSlot = 5'(i);
      #1;
      check(req, {21'd0, rdState, rdPwrLed, rdAttnLed, rdMrlOpen, rdPresence, rdEvents},
            {21'd0, mState[i], mPwr[i], mAttn[i], mMrl[i], mPres[i], mEvt[i]},
            $sformatf("slot %0d {state,pwr,attn,mrl,pres,evt}", i));
    end
    check(req, {27'd0, cmdStatus, cmdDetected}, {27'd0, mInvMode, mInvCmd, 1'b0, 1'b0, mDet},
          "{cmdStatus,cmdDetected}");
  endtask

  task automatic doWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    busyCnt = 0;
    while (busy && busyCnt < 100) begin
      busyCnt++;
      @(negedge clk);
    end
  endtask

  task automatic issue(logic [1:0] a, logic [7:0] d, string req);
    doWrite(a, d);
    waitIdle();
    if (a == 2'd0) begin mCode = d; mExec(); end
    else if (a == 2'd1) begin mTgt = d[4:0]; mExec(); end
    else if (d[0]) mDet = 0;
    compareAll(req);
  endtask

  task automatic doReset(logic [N-1:0] occ);
    rstN = 1'b0;
    occupiedAtReset = occ;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset(occ);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R12 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state for a mix of occupied and empty slots
    doReset(6'b001011);
    @(negedge clk);
    compareAll("R1");

    // R2 R3 R4 R10 R11: every slot code against valid and out-of-range targets
    for (int t = 0; t < 9; t++) begin
      logic [7:0] tw;
      tw = (t == 8) ? 8'd31 : ((t == 4) ? 8'hE4 : 8'(t));
      issue(2'd1, tw, "R10");
      check("R12", busyCnt, 1, "busy cycles single");
      for (int c = 0; c < 64; c++) issue(2'd0, 8'(c), "R2");
      issue(2'd2, 8'h01, "R9");
    end

    // R5: speed range
    for (int s = 0; s < 8; s++) issue(2'd0, 8'h40 | 8'(s), "R5");

    // R8: undefined codes
    issue(2'd0, 8'h4A, "R8");
    issue(2'd0, 8'h4F, "R8");
    issue(2'd0, 8'h50, "R8");
    issue(2'd0, 8'h7F, "R8");
    issue(2'd0, 8'h80, "R8");
    issue(2'd0, 8'hC9, "R8");
    issue(2'd0, 8'hFF, "R8");

    // R6: all-slot commands with enabled slots present
    doReset(6'b001011);
    @(negedge clk);
    compareAll("R1");
    issue(2'd0, 8'h48, "R6");
    issue(2'd0, 8'h49, "R6");
    check("R12", busyCnt, 1, "busy cycles rejected all-slot");
    issue(2'd1, 8'd1, "R6");
    // disable enabled slots with power kept on, then light an empty slot
    issue(2'd0, 8'h07, "R2");
    issue(2'd1, 8'd2, "R10");
    issue(2'd1, 8'd4, "R10");
    issue(2'd1, 8'd3, "R11");

    // R7 R11: accepted all-slot commands
    issue(2'd0, 8'h48, "R7");
    check("R12", busyCnt, N + 1, "busy cycles power-only all");
    issue(2'd0, 8'h49, "R7");
    check("R12", busyCnt, N + 1, "busy cycles enable all");
    issue(2'd0, 8'h49, "R6");

    // R4: enabled slot cannot go to power-only
    issue(2'd1, 8'd1, "R4");
    issue(2'd0, 8'h01, "R4");
    issue(2'd0, 8'h05, "R4");
    issue(2'd0, 8'h3D, "R4");

    // R12: writes while busy are ignored
    issue(2'd0, 8'h07, "R2");
    issue(2'd1, 8'd2, "R10");
    issue(2'd1, 8'd4, "R10");
    doWrite(2'd0, 8'h48);
    doWrite(2'd0, 8'h0F);
    doWrite(2'd2, 8'h01);
    doWrite(2'd1, 8'd3);
    waitIdle();
    mCode = 8'h48;
    mExec();
    compareAll("R12");

    // R9: acknowledge behaviour
    issue(2'd2, 8'h00, "R9");
    issue(2'd2, 8'hFE, "R9");
    issue(2'd2, 8'h01, "R9");
    issue(2'd0, 8'h43, "R9");
    issue(2'd0, 8'h20, "R9");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule